// File: doc/BRIEF.md
# Split Ripple/Lookahead Hybrid Adder

This block is a purely combinational binary adder with a configurable width. A boundary parameter divides the operand bits into two parts. The low part computes its carries through a chain of full-adder cells, where each cell passes its carry to the cell above it. The high part computes all of its carries at once. Each of those carries is a flat sum of products built from per-bit propagate and generate terms and from the carry that enters the high part.

The carry leaving the low chain is the only link between the two parts. It is the incoming carry of the high part. The external carry-in enters bit 0, and the carry leaving the top bit is the carry-out. The block can be used anywhere a plain adder fits. No clock is needed, and the result is valid once the inputs settle.

Top module: `hybrid_adder`

## Requirements
- R1: With WIDTH=8 and the default boundary (SPLIT=4), {cout, sum} equals a + b + cin for every operand pair and for both carry-in values.
- R2: With WIDTH=16 and the default boundary (SPLIT=8), {cout, sum} equals a + b + cin for every applied input.
- R3: cout is 1 exactly when the true value of a + b + cin is at least 2^WIDTH.
- R4: When every bit position propagates (a XOR b is all ones) and cin is 1, sum is all zeros and cout is 1. When both operands are all ones and cin is 1, sum is all ones and cout is 1.
- R5: When both operands and cin are zero, sum and cout are zero.
- R6: A carry that comes out of the low section reaches the high section. For example, a=16'h00FF, b=0, cin=1 gives sum=16'h0100 and cout=0.
- R7: A boundary other than the default (WIDTH=8, SPLIT=3) gives the same exact result as R1 for every input.
- R8: The block has no clock and no storage. The outputs reflect new inputs within the same cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry leaving the top bit |

## Verification
Both 8-bit builds, one with the default boundary and one with a shifted boundary, are driven with every operand pair and every carry-in value. This exposes any wrong product term in the lookahead section and any broken link in the ripple chain. It also shows whether the midpoint carry is wired to the correct bit, because a wrong boundary fails under only some operand values. The 16-bit build receives random vectors plus directed corners: all zeros, all ones, full propagation from cin, and a carry that is born in the low half and must cross into the high half. These corners separate a missing cin term or a missing midpoint link from ordinary generate errors.

// File: rtl/hadd_pkg.sv
`timescale 1ns/1ps
package hadd_pkg;

    // Per-bit carry attributes carried through the datapath
    typedef struct packed {
        logic prop;   // operand bits differ: an incoming carry passes through
        logic gen;    // both operand bits set: a carry is created here
    } bitpg_t;

    function automatic bitpg_t make_pg(input logic x, input logic y);
        bitpg_t r;
        r.prop = x ^ y;
        r.gen  = x & y;
        return r;
    endfunction

    function automatic logic carry_next(input bitpg_t pg, input logic ci);
        return pg.gen | (pg.prop & ci);
    endfunction

    function automatic logic sum_bit(input bitpg_t pg, input logic ci);
        return pg.prop ^ ci;
    endfunction

endpackage

// File: rtl/hadd_pg_gen.sv
`timescale 1ns/1ps
module hadd_pg_gen
    import hadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output bitpg_t [WIDTH-1:0] pg
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pg[i] = make_pg(a[i], b[i]);
    end

endmodule

// File: rtl/hadd_full_add.sv
`timescale 1ns/1ps
module hadd_full_add
    import hadd_pkg::*;
(
    input  bitpg_t pg,
    input  logic   ci,
    output logic   s,
    output logic   co
);

    assign s  = sum_bit(pg, ci);
    assign co = carry_next(pg, ci);

endmodule

// File: rtl/hadd_ripple.sv
`timescale 1ns/1ps
module hadd_ripple
    import hadd_pkg::*;
#(
    parameter int BITS = 4
) (
    input  bitpg_t [BITS-1:0] pg,
    input  logic              cin,
    output logic [BITS-1:0]   sum,
    output logic              cout
);

    logic [BITS:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < BITS; i++) begin : g_stage
        hadd_full_add u_fa (
            .pg (pg[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign cout = chain[BITS];

endmodule

// File: rtl/hadd_lookahead.sv
`timescale 1ns/1ps
module hadd_lookahead
    import hadd_pkg::*;
#(
    parameter int BITS = 4
) (
    input  bitpg_t [BITS-1:0] pg,
    input  logic              cin,
    output logic [BITS-1:0]   sum,
    output logic              cout
);

    logic [BITS:0] cy;

    // Each carry is an independent OR of AND terms; no carry feeds another.
    always_comb begin : p_sop
        logic acc;
        logic term;
        cy    = '0;
        cy[0] = cin;
        for (int k = 1; k <= BITS; k++) begin
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = pg[j].gen;
                for (int m = j + 1; m < k; m++) begin
                    term = term & pg[m].prop;
                end
                acc = acc | term;
            end
            term = cin;
            for (int m = 0; m < k; m++) begin
                term = term & pg[m].prop;
            end
            cy[k] = acc | term;
        end
    end

    for (genvar i = 0; i < BITS; i++) begin : g_sum
        assign sum[i] = sum_bit(pg[i], cy[i]);
    end

    assign cout = cy[BITS];

endmodule

// File: rtl/hybrid_adder.sv
`timescale 1ns/1ps
module hybrid_adder
    import hadd_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SPLIT = WIDTH / 2
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int HI_BITS = WIDTH - SPLIT;

    bitpg_t [WIDTH-1:0] pg;
    logic               mid_carry;

    hadd_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a  (a),
        .b  (b),
        .pg (pg)
    );

    hadd_ripple #(.BITS(SPLIT)) u_low (
        .pg   (pg[SPLIT-1:0]),
        .cin  (cin),
        .sum  (sum[SPLIT-1:0]),
        .cout (mid_carry)
    );

    hadd_lookahead #(.BITS(HI_BITS)) u_high (
        .pg   (pg[WIDTH-1:SPLIT]),
        .cin  (mid_carry),
        .sum  (sum[WIDTH-1:SPLIT]),
        .cout (cout)
    );

endmodule

// File: rtl/hybrid_adder_chk.sv
`timescale 1ns/1ps
module hybrid_adder_chk #(
    parameter int WIDTH = 8,
    parameter int SPLIT = WIDTH / 2
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             mid_carry
);

    logic [WIDTH:0] full_ref;
    logic [SPLIT:0] low_ref;

    always_comb begin
        full_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        low_ref  = {1'b0, a[SPLIT-1:0]} + {1'b0, b[SPLIT-1:0]} + {{SPLIT{1'b0}}, cin};
    end

    always_comb begin
        AST_SUM_EXACT: assert ({cout, sum} == full_ref) else $error("sum mismatch"); // R1
        AST_COUT_RANGE: assert (cout == full_ref[WIDTH]) else $error("carry-out mismatch"); // R3
        AST_ZERO_INPUTS: assert (!(a == '0 && b == '0 && !cin) || (sum == '0 && !cout)) else $error("zero inputs"); // R5
        AST_FULL_PROPAGATE: assert (!((a ^ b) == '1 && cin) || (sum == '0 && cout)) else $error("propagate"); // R4
        AST_MID_CARRY: assert (mid_carry == low_ref[SPLIT]) else $error("midpoint carry"); // R6
    end

endmodule

bind hybrid_adder hybrid_adder_chk #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_chk (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .mid_carry (mid_carry)
);

// File: tb/hybrid_adder_bench.sv
`timescale 1ns/1ps
module hybrid_adder_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;

    logic [7:0]  a8, b8;
    logic        c8;
    logic [15:0] a16, b16;
    logic        c16;

    logic [7:0]  s8, s8x;
    logic        co8, co8x;
    logic [15:0] s16;
    logic        co16;

    hybrid_adder #(.WIDTH(8)) u_hybrid_adder (
        .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(co8)
    );
    hybrid_adder #(.WIDTH(8), .SPLIT(3)) u_hybrid_adder_s3 (
        .a(a8), .b(b8), .cin(c8), .sum(s8x), .cout(co8x)
    );
    hybrid_adder #(.WIDTH(16)) u_hybrid_adder_w16 (
        .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16)
    );

    typedef struct {
        logic [8:0]  e8;
        logic [16:0] e16;
        logic [7:0]  x8, y8;
        logic        ci8;
        logic [15:0] x16, y16;
        logic        ci16;
        string       tag16;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] x, input logic [7:0] y, input logic ci,
                         input logic [15:0] u, input logic [15:0] v, input logic cu,
                         input string tag);
        item_t it;
        @(negedge clk);
        a8 = x; b8 = y; c8 = ci;
        a16 = u; b16 = v; c16 = cu;
        it.e8   = {1'b0, x} + {1'b0, y} + {8'd0, ci};
        it.e16  = {1'b0, u} + {1'b0, v} + {16'd0, cu};
        it.x8 = x; it.y8 = y; it.ci8 = ci;
        it.x16 = u; it.y16 = v; it.ci16 = cu;
        it.tag16 = tag;
        q.push_back(it);
    endtask

    // Monitor: compare at the edge following each drive
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check({co8, s8} == it.e8, "R1", {co8, s8}, it.e8);
            check(co8 == it.e8[8], "R3", co8, it.e8[8]);
            check({co8x, s8x} == it.e8, "R7", {co8x, s8x}, it.e8);
            check({co16, s16} == it.e16, it.tag16, {co16, s16}, it.e16);
        end
    end

    initial begin
        rst = 1'b1;
        a8 = '0; b8 = '0; c8 = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R5: all-zero inputs give zero outputs
        check(s8 == 8'h00 && !co8, "R5", {co8, s8}, 0);
        check(s16 == 16'h0000 && !co16, "R5", {co16, s16}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R8: outputs follow inputs without a clock edge
        @(negedge clk);
        a16 = 16'h1234; b16 = 16'h0F0F; c16 = 1'b1;
        #1;
        check({co16, s16} == 17'h02144, "R8", {co16, s16}, 17'h02144);

        // R1/R7 exhaustive at 8 bits, R2 random at 16 bits
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    drive(x[7:0], y[7:0], ci[0], 16'($urandom), 16'($urandom), 1'($urandom), "R2");
                end
            end
        end

        // Directed 16-bit corners
        drive(8'hFF, 8'h00, 1'b1, 16'hFFFF, 16'h0000, 1'b1, "R4");
        drive(8'hA5, 8'h5A, 1'b1, 16'hA5A5, 16'h5A5A, 1'b1, "R4");
        drive(8'hFF, 8'hFF, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, "R4");
        drive(8'h00, 8'h00, 1'b0, 16'h0000, 16'h0000, 1'b0, "R5");
        drive(8'h0F, 8'h00, 1'b1, 16'h00FF, 16'h0000, 1'b1, "R6");
        drive(8'h08, 8'h08, 1'b0, 16'h00FF, 16'h0001, 1'b0, "R6");
        drive(8'h80, 8'h80, 1'b0, 16'h8000, 16'h8000, 1'b0, "R3");
        drive(8'h7F, 8'h80, 1'b0, 16'h7FFF, 16'h8000, 1'b0, "R3");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        // R6 explicit expected value at the ports
        a16 = 16'h00FF; b16 = 16'h0000; c16 = 1'b1;
        #1;
        check({co16, s16} == 17'h00100, "R6", {co16, s16}, 17'h00100);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule